// File: doc/BRIEF.md
# Interrupt-capable memory-mapped GPIO controller

This block is a general-purpose I/O controller for up to 32 pins. Software reaches it through a single-cycle register bus with a write strobe, a read strobe, a byte address and 32-bit data. Each pin has an output value and an output enable. The output enable comes straight from the direction register. A two-flop synchronizer samples the pin inputs before any other logic sees them.

Each pin can raise an interrupt on a rising edge, a falling edge, both edges, a high level or a low level. The mode comes from three independent bit-vectors: edge-or-level select, polarity, and a both-edge override. Edge events are latched until software clears them. Level conditions track the synchronized input and are never latched. Per-pin enable and mask vectors gate what reaches the status word. The single interrupt output is the OR of the status bits. Output data can be changed without a read-modify-write by writing to set and clear alias words. Pull and debounce settings are held as plain read/write storage for logic outside this block.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After a clocked active-low reset every register is zero: `pin_out` and `pin_oe` are 0, `irq` is 0, and reading any offset returns 0.
- R2: A write to offset 0x00 (output data) or offset 0x08 (direction, 1 = output) appears on `pin_out` / `pin_oe` on the cycle after the write, and both words read back what was written.
- R3: A write to offset 0x10 sets each output bit whose written bit is 1. A write to offset 0x14 clears each output bit whose written bit is 1. Output bits written as 0 keep their value. Both offsets read as 0.
- R4: Offset 0x04 returns the pin inputs after a two-flop synchronizer, so the value read is `pin_in` as it was two clock edges earlier. Writes to this offset are ignored.
- R5: Offsets 0x18 (pull enable), 0x1C (pull select), 0x40 (debounce enable) and 0x44 (debounce prescale) are read/write storage that reads back what was last written.
- R6: A pin whose bit in offset 0x34 is 0 is edge-sensitive. If its bit in offset 0x3C is 0 it latches a pending bit on a rising edge of the synchronized input; if that bit is 1 it latches on a falling edge.
- R7: An edge-sensitive pin whose bit in offset 0x38 is 1 latches on both rising and falling edges, whatever its bit in offset 0x3C says.
- R8: A pin whose bit in offset 0x34 is 1 is level-sensitive. Its pending bit is 1 exactly while the synchronized input is high (bit in 0x3C = 0) or low (bit in 0x3C = 1). It is never latched.
- R9: Writing 1 to a bit of offset 0x30 clears that pin's latched edge. This offset reads as 0. If a new edge is detected in the same cycle as the clear, the pin stays pending.
- R10: A 1 in offset 0x2C hides that pin's pending bit from the status word and from `irq`. A latched edge is kept while it is hidden and shows again when the mask bit returns to 0.
- R11: A pin whose bit in offset 0x20 is 0 shows no pending bit. An edge that occurs while the pin is disabled is not latched.
- R12: Offset 0x24 returns the per-pin status word (pending, enabled and unmasked). `irq` is 1 exactly when that word is nonzero. Writes to offset 0x24 are ignored.
- R13: Offsets outside the map read as 0 and ignore writes; the two low address bits are ignored. Read data is registered: it appears on the cycle after `bus_rd` and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe, one cycle per access |
| bus_rd | input | 1 | Register read strobe, one cycle per access |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | NPIN | Raw pin input levels |
| pin_out | output | NPIN | Output data for each pin |
| pin_oe | output | NPIN | Output enable for each pin (1 = drive) |
| irq | output | 1 | Combined interrupt request |

## Verification
The hardest case to reach from the ports is an edge that reaches the detector in the same cycle as a write to the clear word. The edge passes through the synchronizer and the previous-value register, so it is detected two clock edges after the pin changes. The stimulus changes the pin on a falling clock edge and starts the clear write exactly two falling edges later, so that both land on the same rising edge; the status read that follows must still show the pin as pending. Masking over a latched edge, and edges that occur while a pin is disabled, are reached by reordering the configuration writes around the pin changes. A cycle-accurate behavioural model in the bench checks every output on every clock throughout.

// File: rtl/gpio_irq_pkg.sv
// gpio_irq_pkg: shared constants for the GPIO controller.
// Register selectors are word indices (byte offset divided by four).
// Assumes a 32-bit bus and an 8-bit byte address.
package gpio_irq_pkg;
    localparam int BUS_W  = 32;
    localparam int ADDR_W = 8;
    localparam int SEL_W  = ADDR_W - 2;

    localparam logic [SEL_W-1:0] RA_DOUT  = 6'h00;
    localparam logic [SEL_W-1:0] RA_DIN   = 6'h01;
    localparam logic [SEL_W-1:0] RA_DIR   = 6'h02;
    localparam logic [SEL_W-1:0] RA_SET   = 6'h04;
    localparam logic [SEL_W-1:0] RA_CLR   = 6'h05;
    localparam logic [SEL_W-1:0] RA_PEN   = 6'h06;
    localparam logic [SEL_W-1:0] RA_PSEL  = 6'h07;
    localparam logic [SEL_W-1:0] RA_IEN   = 6'h08;
    localparam logic [SEL_W-1:0] RA_ISTAT = 6'h09;
    localparam logic [SEL_W-1:0] RA_IMASK = 6'h0B;
    localparam logic [SEL_W-1:0] RA_ICLR  = 6'h0C;
    localparam logic [SEL_W-1:0] RA_ITYPE = 6'h0D;
    localparam logic [SEL_W-1:0] RA_IBOTH = 6'h0E;
    localparam logic [SEL_W-1:0] RA_ILVL  = 6'h0F;
    localparam logic [SEL_W-1:0] RA_DBEN  = 6'h10;
    localparam logic [SEL_W-1:0] RA_DBPS  = 6'h11;
endpackage

// File: rtl/gpio_pin_sync.sv
// gpio_pin_sync: two-flop synchronizer for the pin inputs.
// Assumes the pins are asynchronous to clk; the output is the input delayed by two edges.
module gpio_pin_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    // Two-stage capture of the raw pins
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= pin_i;
            sync_q <= meta_q;
        end
    end

    assign sync_o = sync_q;

    // Counts cycles since reset so the delay check only looks at valid history
    logic [1:0] warm_q;
    always_ff @(posedge clk) begin
        if (!rst_n)              warm_q <= '0;
        else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
    end

    // R4
    sync_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q >= 2'd2) |-> (sync_o == $past(pin_i, 2)));
endmodule

// File: rtl/gpio_irq_detect.sv
// gpio_irq_detect: per-pin interrupt condition detection and edge latching.
// Assumes sync_i is already synchronized. The mode for each pin comes from three vectors:
// type (1 = level), lvl (1 = low or falling) and both (both edges, edge mode only).
module gpio_irq_detect #(
    parameter int NPIN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NPIN-1:0] sync_i,
    input  logic [NPIN-1:0] en_i,
    input  logic [NPIN-1:0] type_i,
    input  logic [NPIN-1:0] lvl_i,
    input  logic [NPIN-1:0] both_i,
    input  logic [NPIN-1:0] clr_i,
    output logic [NPIN-1:0] pend_o
);
    logic [NPIN-1:0] prev_q;
    logic [NPIN-1:0] latch_q;
    logic [NPIN-1:0] edge_hit;
    logic [NPIN-1:0] lvl_act;

    // Previous synchronized value for edge comparison
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= sync_i;
    end

    for (genvar i = 0; i < NPIN; i++) begin : g_pin
        logic rise, fall;
        assign rise = sync_i[i] & ~prev_q[i];
        assign fall = ~sync_i[i] & prev_q[i];
        // Edge event qualified by enable and edge mode
        assign edge_hit[i] = en_i[i] & ~type_i[i] &
                             (both_i[i] ? (rise | fall) : (lvl_i[i] ? fall : rise));
        // Level condition, live and unlatched
        assign lvl_act[i]  = en_i[i] & type_i[i] & (sync_i[i] ^ lvl_i[i]);
        assign pend_o[i]   = en_i[i] & (type_i[i] ? lvl_act[i] : latch_q[i]);
    end

    // Edge latch: a new hit overrides a clear in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n) latch_q <= '0;
        else        latch_q <= (latch_q & ~clr_i) | edge_hit;
    end

    // R9
    clr_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((latch_q & $past(clr_i & ~edge_hit)) == '0));

    // R9
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((~latch_q & $past(edge_hit)) == '0));

    // R11
    no_latch_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((latch_q & ~$past(latch_q) & ~$past(en_i)) == '0));
endmodule

// File: rtl/gpio_irq_ctrl.sv
// gpio_irq_ctrl: register file, pin drive and interrupt combine for the GPIO controller.
// Assumes single-cycle accesses with at most one strobe per cycle; read data is registered.
module gpio_irq_ctrl
    import gpio_irq_pkg::*;
#(
    parameter int NPIN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic [NPIN-1:0]   pin_in,
    output logic [NPIN-1:0]   pin_out,
    output logic [NPIN-1:0]   pin_oe,
    output logic              irq
);
    logic [SEL_W-1:0] sel;
    logic [NPIN-1:0]  wpins;
    logic [NPIN-1:0]  dout_q, dir_q, pen_q, psel_q, dben_q;
    logic [NPIN-1:0]  ien_q, imask_q, itype_q, iboth_q, ilvl_q;
    logic [BUS_W-1:0] dbps_q;
    logic [NPIN-1:0]  sync_w, pend_w, status_w, clr_w;
    logic [BUS_W-1:0] rd_mux;
    logic             unused_lsb;

    assign sel        = bus_addr[ADDR_W-1:2];
    assign wpins      = bus_wdata[NPIN-1:0];
    assign unused_lsb = ^bus_addr[1:0];

    gpio_pin_sync #(.W(NPIN)) sync_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (pin_in),
        .sync_o (sync_w)
    );

    // Write-one clear pulse toward the edge latches
    assign clr_w = (bus_wr && sel == RA_ICLR) ? wpins : '0;

    gpio_irq_detect #(.NPIN(NPIN)) det_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .sync_i (sync_w),
        .en_i   (ien_q),
        .type_i (itype_q),
        .lvl_i  (ilvl_q),
        .both_i (iboth_q),
        .clr_i  (clr_w),
        .pend_o (pend_w)
    );

    // Register writes, including atomic set/clear of the output data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout_q  <= '0; dir_q   <= '0; pen_q   <= '0; psel_q <= '0;
            ien_q   <= '0; imask_q <= '0; itype_q <= '0; iboth_q <= '0;
            ilvl_q  <= '0; dben_q  <= '0; dbps_q  <= '0;
        end else if (bus_wr) begin
            case (sel)
                RA_DOUT:  dout_q  <= wpins;
                RA_SET:   dout_q  <= dout_q | wpins;
                RA_CLR:   dout_q  <= dout_q & ~wpins;
                RA_DIR:   dir_q   <= wpins;
                RA_PEN:   pen_q   <= wpins;
                RA_PSEL:  psel_q  <= wpins;
                RA_IEN:   ien_q   <= wpins;
                RA_IMASK: imask_q <= wpins;
                RA_ITYPE: itype_q <= wpins;
                RA_IBOTH: iboth_q <= wpins;
                RA_ILVL:  ilvl_q  <= wpins;
                RA_DBEN:  dben_q  <= wpins;
                RA_DBPS:  dbps_q  <= bus_wdata;
                default:  ;
            endcase
        end
    end

    // Status: pending bits that are not masked
    assign status_w = pend_w & ~imask_q;
    assign irq      = |status_w;
    assign pin_out  = dout_q;
    assign pin_oe   = dir_q;

    // Read selection; write-only, alias and unmapped words return zero
    always_comb begin
        rd_mux = '0;
        case (sel)
            RA_DOUT:  rd_mux[NPIN-1:0] = dout_q;
            RA_DIN:   rd_mux[NPIN-1:0] = sync_w;
            RA_DIR:   rd_mux[NPIN-1:0] = dir_q;
            RA_PEN:   rd_mux[NPIN-1:0] = pen_q;
            RA_PSEL:  rd_mux[NPIN-1:0] = psel_q;
            RA_IEN:   rd_mux[NPIN-1:0] = ien_q;
            RA_ISTAT: rd_mux[NPIN-1:0] = status_w;
            RA_IMASK: rd_mux[NPIN-1:0] = imask_q;
            RA_ITYPE: rd_mux[NPIN-1:0] = itype_q;
            RA_IBOTH: rd_mux[NPIN-1:0] = iboth_q;
            RA_ILVL:  rd_mux[NPIN-1:0] = ilvl_q;
            RA_DBEN:  rd_mux[NPIN-1:0] = dben_q;
            RA_DBPS:  rd_mux           = dbps_q;
            default:  rd_mux           = '0;
        endcase
    end

    // Registered read data, held between reads
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_mux;
    end

    // R1
    reset_clean_chk: assert property (@(posedge clk)
        !rst_n |=> (pin_oe == '0 && pin_out == '0 && !irq && bus_rdata == '0));

    // R3
    set_alias_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && sel == RA_SET) |=> (pin_out == ($past(pin_out) | $past(wpins))));

    // R3
    clr_alias_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && sel == RA_CLR) |=> (pin_out == ($past(pin_out) & ~$past(wpins))));

    // R11
    all_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ien_q == '0) |-> !irq);

    // R13
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));
endmodule

// File: tb/gpio_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module gpio_irq_ctrl_tb_top;
    localparam int NPIN = 32;
    localparam logic [7:0] A_DOUT = 8'h00, A_DIN = 8'h04, A_DIR = 8'h08, A_SET = 8'h10,
                           A_CLR = 8'h14, A_PEN = 8'h18, A_PSEL = 8'h1C, A_IEN = 8'h20,
                           A_ISTAT = 8'h24, A_IMASK = 8'h2C, A_ICLR = 8'h30, A_ITYPE = 8'h34,
                           A_IBOTH = 8'h38, A_ILVL = 8'h3C, A_DBEN = 8'h40, A_DBPS = 8'h44;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]      bus_addr = '0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic [NPIN-1:0] pin_in = '0;
    logic [NPIN-1:0] pin_out, pin_oe;
    logic            irq;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    gpio_irq_ctrl #(.NPIN(NPIN)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    // Behavioural reference model, stepped on every rising edge
    bit [31:0] m_reg [0:17];   // indexed by byte offset / 4
    bit [31:0] m_s1, m_s2, m_prev, m_lat, m_rd;

    function automatic bit [31:0] m_status();
        bit [31:0] s = 0;
        for (int i = 0; i < NPIN; i++) begin
            bit p;
            if (m_reg[13][i]) p = m_reg[8][i] && (m_s2[i] != m_reg[15][i]);
            else              p = m_reg[8][i] && m_lat[i];
            s[i] = p && !m_reg[11][i];
        end
        return s;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < 18; k++) m_reg[k] = 0;
            m_s1 = 0; m_s2 = 0; m_prev = 0; m_lat = 0; m_rd = 0;
        end else begin
            int w;
            bit [31:0] nlat;
            w = int'(bus_addr[7:2]);
            if (bus_rd) begin
                case (w)
                    1:  m_rd = m_s2;
                    9:  m_rd = m_status();
                    0, 2, 6, 7, 8, 11, 13, 14, 15, 16, 17: m_rd = m_reg[w];
                    default: m_rd = 0;
                endcase
            end
            for (int i = 0; i < NPIN; i++) begin
                bit r, f, hit;
                r = m_s2[i] && !m_prev[i];
                f = !m_s2[i] && m_prev[i];
                hit = 0;
                if (m_reg[8][i] && !m_reg[13][i]) begin
                    if (m_reg[14][i])      hit = r || f;
                    else if (m_reg[15][i]) hit = f;
                    else                   hit = r;
                end
                nlat[i] = hit || (m_lat[i] && !(bus_wr && w == 12 && bus_wdata[i]));
            end
            m_lat = nlat;
            if (bus_wr) begin
                case (w)
                    4: m_reg[0] = m_reg[0] | bus_wdata;
                    5: m_reg[0] = m_reg[0] & ~bus_wdata;
                    0, 2, 6, 7, 8, 11, 13, 14, 15, 16, 17: m_reg[w] = bus_wdata;
                    default: ;
                endcase
            end
            m_prev = m_s2; m_s2 = m_s1; m_s1 = pin_in;
        end
    end

    // Per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            checks++;
            if (pin_out !== m_reg[0] || pin_oe !== m_reg[2] || irq !== (m_status() != 0)
                || bus_rdata !== m_rd) begin
                errors++;
                $display("FAIL model R12/R13: out=%h oe=%h irq=%b rd=%h exp out=%h oe=%h irq=%b rd=%h",
                         pin_out, pin_oe, irq, bus_rdata, m_reg[0], m_reg[2],
                         m_status() != 0, m_rd);
            end
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] v);
        @(negedge clk); bus_rd = 1'b1; bus_addr = a;
        @(negedge clk); bus_rd = 1'b0; v = bus_rdata;
    endtask

    task automatic pins(logic [NPIN-1:0] v);
        @(negedge clk); pin_in = v;
        repeat (4) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 pin_oe", pin_oe, 0);
        chk("R1 pin_out", pin_out, 0);
        chk("R1 irq", {31'd0, irq}, 0);
        rd(A_IEN, v);  chk("R1 ien read", v, 0);
        // R2 output data and direction
        wr(A_DOUT, 32'h0000_00F0);
        wr(A_DIR, 32'hFFFF_0000);
        chk("R2 pin_out", pin_out, 32'h0000_00F0);
        chk("R2 pin_oe", pin_oe, 32'hFFFF_0000);
        rd(A_DIR, v);  chk("R2 dir read", v, 32'hFFFF_0000);
        // R3 set and clear aliases
        wr(A_SET, 32'h0F00_000F);
        chk("R3 set", pin_out, 32'h0F00_00FF);
        wr(A_CLR, 32'h0000_00F0);
        chk("R3 clear", pin_out, 32'h0F00_000F);
        rd(A_SET, v);  chk("R3 set alias read", v, 0);
        rd(A_CLR, v);  chk("R3 clear alias read", v, 0);
        // R4 synchronized input
        pins(32'hA5A5_0000);
        rd(A_DIN, v);  chk("R4 data in", v, 32'hA5A5_0000);
        wr(A_DIN, 32'h1234_5678);
        rd(A_DIN, v);  chk("R4 data in write ignored", v, 32'hA5A5_0000);
        // R5 storage words
        wr(A_PEN, 32'h1111_2222); wr(A_PSEL, 32'h3333_4444);
        wr(A_DBEN, 32'h5555_6666); wr(A_DBPS, 32'h0000_BEEF);
        rd(A_PEN, v);  chk("R5 pull enable", v, 32'h1111_2222);
        rd(A_PSEL, v); chk("R5 pull select", v, 32'h3333_4444);
        rd(A_DBEN, v); chk("R5 debounce enable", v, 32'h5555_6666);
        rd(A_DBPS, v); chk("R5 debounce prescale", v, 32'h0000_BEEF);
        // Interrupt setup: pin0 rise, pin1 fall, pin2 both, pin3 high level, pin4 low level
        pins(32'h0);
        wr(A_ITYPE, 32'h18); wr(A_ILVL, 32'h12); wr(A_IBOTH, 32'h04); wr(A_IEN, 32'h1F);
        rd(A_ISTAT, v); chk("R8 low level active", v, 32'h10);
        chk("R12 irq on", {31'd0, irq}, 1);
        pins(32'h18);
        rd(A_ISTAT, v); chk("R8 level follows input", v, 32'h08);
        pins(32'h1F);
        rd(A_ISTAT, v); chk("R6 R7 rising edges", v, 32'h0D);
        pins(32'h10);
        rd(A_ISTAT, v); chk("R6 R7 falling edges", v, 32'h07);
        wr(A_ICLR, 32'h07);
        rd(A_ISTAT, v); chk("R9 clear", v, 0);
        chk("R12 irq off", {31'd0, irq}, 0);
        rd(A_ICLR, v);  chk("R9 clear reads zero", v, 0);
        // R10 mask keeps the latch
        pins(32'h11);
        rd(A_ISTAT, v); chk("R10 before mask", v, 32'h01);
        wr(A_IMASK, 32'h01);
        rd(A_ISTAT, v); chk("R10 masked status", v, 0);
        chk("R10 masked irq", {31'd0, irq}, 0);
        wr(A_IMASK, 32'h00);
        rd(A_ISTAT, v); chk("R10 unmasked again", v, 32'h01);
        wr(A_ICLR, 32'h01);
        // R11 disabled pin does not latch
        pins(32'h31);
        rd(A_ISTAT, v); chk("R11 disabled edge", v, 0);
        wr(A_IEN, 32'h3F);
        rd(A_ISTAT, v); chk("R11 no stale latch", v, 0);
        // R9 edge detected in the same cycle as the clear
        pins(32'h30);
        @(negedge clk); pin_in = 32'h31;
        @(negedge clk);
        @(negedge clk); bus_wr = 1'b1; bus_addr = A_ICLR; bus_wdata = 32'h1;
        @(negedge clk); bus_wr = 1'b0;
        rd(A_ISTAT, v); chk("R9 set wins", v, 32'h01);
        // R12 status write ignored, R13 unmapped offsets and low address bits
        wr(A_ISTAT, 32'hFFFF_FFFF);
        rd(A_ISTAT, v); chk("R12 status write ignored", v, 32'h01);
        wr(8'h0C, 32'hFFFF_FFFF); wr(8'h28, 32'hFFFF_FFFF);
        rd(8'h0C, v);  chk("R13 unmapped 0x0C", v, 0);
        rd(8'h28, v);  chk("R13 unmapped 0x28", v, 0);
        rd(8'h48, v);  chk("R13 unmapped 0x48", v, 0);
        rd(8'h0B, v);  chk("R13 low bits ignored", v, 32'hFFFF_0000);
        rd(A_DOUT, v); chk("R13 data out untouched", v, 32'h0F00_000F);
        repeat (2) @(negedge clk);
        chk("R13 read data holds", bus_rdata, 32'h0F00_000F);
        finish_run();
    end
endmodule